// File: doc/BRIEF.md
# Chip-Select-Qualified Window Watchdog Supervisor

This block supervises a microcontroller through its SPI link. The SPI front end has already parsed each command word. It hands the fields over with a one-cycle strobe while chip select is low. The fields are a service bit, a 3-bit off code, a hold-length write enable and a hold-length value. The block captures them and acts on them only when chip select returns high. It brings chip select into its own clock domain through a two-flop synchroniser and detects the edge there. A frame whose service bit is clear therefore leaves the watchdog alone, so software can poll status over SPI at any time.

The supervision period has two parts. First comes a closed window of `CLOSED_TICKS` prescaled ticks, then an open window of `OPEN_TICKS` ticks. Each tick lasts `PRESC_DIV` clocks. A watchdog fault is either a service event in the closed window, or no service event before the open window ends. A fault raises the reset output for the programmed hold length, measured in ticks. After the hold, a new closed window starts. A service event in the open window also starts a new closed window. The hold length has a default that is scaled by a parameter. The default returns after a chip reset and whenever the supply-good input has been low. While the supply stays good, the last written value is kept. A low-active error output flags an active watchdog reset or a bad supply.

Top module: `spi_window_wdog`

## Requirements
- R1: Command fields are captured only on a `cmdValid` strobe while the synchronised chip select is low. A strobe while chip select is high is dropped. A chip-select rise with no captured command changes nothing.
- R2: A captured frame with `cmdTrig`=1 acts at the third clock edge after `csN` rises. If that edge falls in the open window, a new closed window starts there, so the next timeout fault comes (CLOSED_TICKS+OPEN_TICKS)*PRESC_DIV clocks later.
- R3: A service event whose acting edge falls in the closed window raises `wdReset` at that edge.
- R4: A frame with `cmdTrig`=0 is not a service event. In either window it neither causes a fault nor moves the timeout.
- R5: With no service event, `wdReset` rises exactly (CLOSED_TICKS+OPEN_TICKS)*PRESC_DIV clocks after the window start. A window starts at reset release or at the falling edge of `wdReset`.
- R6: `wdReset` stays high for exactly hold*PRESC_DIV clocks, where a hold value of 0 counts as 1. It then falls and a closed window begins.
- R7: A frame with `cmdDisable`=3'b010 stops the watchdog, and this takes priority over its service bit. While stopped, `wdReset` stays low and service frames are ignored. A later frame with any other `cmdDisable` code restarts the watchdog at a closed window.
- R8: The hold length is DEFAULT_DLY ticks after reset and after any time `supplyOk` was low. The input is synchronised through two flops.
- R9: While `supplyOk` stays high, the hold length is the `cmdDelay` value of the last frame that had `cmdDlyWr`=1. Other frames leave it unchanged.
- R10: `errN` is low while `wdReset` is high or while the synchronised `supplyOk` is low, including during reset. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | SPI chip select, active low, asynchronous to clk |
| cmdValid | input | 1 | One-cycle strobe: parsed command fields are valid |
| cmdTrig | input | 1 | Watchdog service bit of the command |
| cmdDisable | input | 3 | Off code; 3'b010 stops the watchdog |
| cmdDlyWr | input | 1 | Write enable for the hold length |
| cmdDelay | input | DLY_W | Hold length in ticks |
| supplyOk | input | 1 | Logic supply above its threshold |
| wdReset | output | 1 | Watchdog reset to the microcontroller, active high |
| errN | output | 1 | Error flag, active low |

## Verification
The bench builds the block with PRESC_DIV=4, CLOSED_TICKS=8, OPEN_TICKS=8, DLY_W=6 and DEFAULT_DLY=12. With these values a full period is 64 clocks and the default hold is 48 clocks. Every window boundary, timeout, hold length and restart can then be measured to the exact clock in a few hundred cycles. The small hold width also lets a written hold of 5 ticks be told apart from the default.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [1:0] {
    PH_CLOSED = 2'd0,
    PH_OPEN   = 2'd1,
    PH_HOLD   = 2'd2,
    PH_OFF    = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   clrWin;
    logic   applyCfg;
    phase_e phase;
  } ctrl_strb_t;

  // status from datapath to control
  typedef struct packed {
    logic csRise;
    logic winDone;
    logic frameValid;
    logic frameTrig;
    logic frameOff;
  } dp_stat_t;

  localparam logic [2:0] OFF_CODE = 3'b010;

endpackage

// File: rtl/swd_dpath.sv
module swd_dpath
  import swd_pkg::*;
#(
  parameter int PRESC_DIV    = 1000,
  parameter int CLOSED_TICKS = 20,
  parameter int OPEN_TICKS   = 80,
  parameter int DLY_W        = 8,
  parameter int DEFAULT_DLY  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             cmdValid,
  input  logic             cmdTrig,
  input  logic [2:0]       cmdDisable,
  input  logic             cmdDlyWr,
  input  logic [DLY_W-1:0] cmdDelay,
  input  logic             supplyOk,
  input  ctrl_strb_t       strb,
  output dp_stat_t         stat,
  output logic             supplyLow
);

  localparam int PS_W   = (PRESC_DIV > 2) ? $clog2(PRESC_DIV) : 1;
  localparam int MAXA   = (CLOSED_TICKS > OPEN_TICKS) ? CLOSED_TICKS : OPEN_TICKS;
  localparam int MAXLIM = (MAXA > (1 << DLY_W)) ? MAXA : (1 << DLY_W);
  localparam int CNT_W  = $clog2(MAXLIM + 1);

  localparam logic [PS_W-1:0]  PS_LAST  = PS_W'(PRESC_DIV - 1);
  localparam logic [CNT_W-1:0] LIM_CLS  = CNT_W'(CLOSED_TICKS);
  localparam logic [CNT_W-1:0] LIM_OPN  = CNT_W'(OPEN_TICKS);
  localparam logic [DLY_W-1:0] DLY_DEF  = DLY_W'(DEFAULT_DLY);

  // chip select synchroniser and edge detect
  logic [2:0] csSh;
  logic       csHigh;
  logic       csRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csSh <= 3'b111;
    else       csSh <= {csSh[1:0], csN};
  end

  assign csHigh = csSh[1];
  assign csRise = csSh[1] & ~csSh[2];

  // supply-good synchroniser
  logic [1:0] supSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) supSh <= 2'b00;
    else       supSh <= {supSh[0], supplyOk};
  end

  assign supplyLow = ~supSh[1];

  // captured frame fields
  logic             pendValid;
  logic             pendTrig;
  logic [2:0]       pendDis;
  logic             pendDlyWr;
  logic [DLY_W-1:0] pendDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendTrig  <= 1'b0;
      pendDis   <= 3'b000;
      pendDlyWr <= 1'b0;
      pendDly   <= '0;
    end else if (csRise) begin
      pendValid <= 1'b0;
      pendTrig  <= 1'b0;
      pendDlyWr <= 1'b0;
    end else if (cmdValid && !csHigh) begin
      pendValid <= 1'b1;
      pendTrig  <= cmdTrig;
      pendDis   <= cmdDisable;
      pendDlyWr <= cmdDlyWr;
      pendDly   <= cmdDelay;
    end
  end

  // tick prescaler
  logic [PS_W-1:0] psCnt;
  logic            tick;

  assign tick = (psCnt == PS_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            psCnt <= '0;
    else if (strb.clrWin) psCnt <= '0;
    else if (tick)        psCnt <= '0;
    else                  psCnt <= psCnt + 1'b1;
  end

  // window / hold tick counter, shared by all phases
  logic [CNT_W-1:0] winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            winCnt <= '0;
    else if (strb.clrWin) winCnt <= '0;
    else if (tick)        winCnt <= winCnt + 1'b1;
  end

  // hold length register
  logic [DLY_W-1:0] dlyReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            dlyReg <= DLY_DEF;
    else if (supplyLow)                   dlyReg <= DLY_DEF;
    else if (strb.applyCfg && pendDlyWr)  dlyReg <= pendDly;
  end

  logic [CNT_W-1:0] effDly;
  logic [CNT_W-1:0] limit;

  assign effDly = (dlyReg == '0) ? CNT_W'(1) : CNT_W'(dlyReg);

  always_comb begin
    case (strb.phase)
      PH_CLOSED: limit = LIM_CLS;
      PH_OPEN:   limit = LIM_OPN;
      PH_HOLD:   limit = effDly;
      default:   limit = LIM_CLS;
    endcase
  end

  assign stat.csRise     = csRise;
  assign stat.winDone    = tick && (winCnt == (limit - CNT_W'(1))) && (strb.phase != PH_OFF);
  assign stat.frameValid = pendValid;
  assign stat.frameTrig  = pendValid && pendTrig;
  assign stat.frameOff   = pendValid && (pendDis == OFF_CODE);

  AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && csHigh && !csRise |=> $stable(pendValid) && $stable(pendTrig)) // R1
    else $error("capture while chip select high");

  AST_DELAY_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> dlyReg == DLY_DEF) // R8
    else $error("hold length not restored");

  AST_DELAY_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !supplyLow && !strb.applyCfg |=> $stable(dlyReg)) // R9
    else $error("hold length changed without a write");

endmodule

// File: rtl/swd_ctrl.sv
module swd_ctrl
  import swd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dp_stat_t   stat,
  output ctrl_strb_t strb,
  output logic       wdReset
);

  phase_e phase;
  phase_e phaseNxt;

  always_comb begin
    phaseNxt = phase;
    if (stat.csRise && stat.frameOff) begin
      phaseNxt = PH_OFF;
    end else begin
      case (phase)
        PH_OFF: begin
          if (stat.csRise && stat.frameValid) phaseNxt = PH_CLOSED;
        end
        PH_CLOSED: begin
          if (stat.csRise && stat.frameTrig) phaseNxt = PH_HOLD;
          else if (stat.winDone)             phaseNxt = PH_OPEN;
        end
        PH_OPEN: begin
          if (stat.csRise && stat.frameTrig) phaseNxt = PH_CLOSED;
          else if (stat.winDone)             phaseNxt = PH_HOLD;
        end
        PH_HOLD: begin
          if (stat.winDone) phaseNxt = PH_CLOSED;
        end
        default: phaseNxt = PH_CLOSED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_CLOSED;
    else       phase <= phaseNxt;
  end

  assign strb.clrWin   = (phaseNxt != phase);
  assign strb.applyCfg = stat.csRise && stat.frameValid;
  assign strb.phase    = phase;
  assign wdReset       = (phase == PH_HOLD);

  AST_EARLY_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_CLOSED && stat.csRise && stat.frameTrig && !stat.frameOff |=> wdReset) // R3
    else $error("early service did not fault");

  AST_READ_NO_SERVICE: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_OPEN && stat.csRise && stat.frameValid && !stat.frameTrig
    && !stat.frameOff && !stat.winDone |=> phase == PH_OPEN) // R4
    else $error("read frame changed the window");

  AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wdReset) |-> phase == PH_CLOSED || phase == PH_OFF) // R6
    else $error("hold left to a wrong phase");

  AST_OFF_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_OFF && !stat.csRise |=> phase == PH_OFF) // R7
    else $error("left off state without a frame");

endmodule

// File: rtl/spi_window_wdog.sv
module spi_window_wdog
  import swd_pkg::*;
#(
  parameter int PRESC_DIV    = 1000,
  parameter int CLOSED_TICKS = 20,
  parameter int OPEN_TICKS   = 80,
  parameter int DLY_W        = 8,
  parameter int DEFAULT_DLY  = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             cmdValid,
  input  logic             cmdTrig,
  input  logic [2:0]       cmdDisable,
  input  logic             cmdDlyWr,
  input  logic [DLY_W-1:0] cmdDelay,
  input  logic             supplyOk,
  output logic             wdReset,
  output logic             errN
);

  ctrl_strb_t strb;
  dp_stat_t   stat;
  logic       supplyLow;

  swd_dpath #(
    .PRESC_DIV   (PRESC_DIV),
    .CLOSED_TICKS(CLOSED_TICKS),
    .OPEN_TICKS  (OPEN_TICKS),
    .DLY_W       (DLY_W),
    .DEFAULT_DLY (DEFAULT_DLY)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .cmdValid  (cmdValid),
    .cmdTrig   (cmdTrig),
    .cmdDisable(cmdDisable),
    .cmdDlyWr  (cmdDlyWr),
    .cmdDelay  (cmdDelay),
    .supplyOk  (supplyOk),
    .strb      (strb),
    .stat      (stat),
    .supplyLow (supplyLow)
  );

  swd_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .stat   (stat),
    .strb   (strb),
    .wdReset(wdReset)
  );

  assign errN = ~(wdReset | supplyLow);

endmodule

// File: tb/test_spi_window_wdog.sv
module test_spi_window_wdog;

  localparam int DIV  = 4;
  localparam int CLS  = 8;
  localparam int OPN  = 8;
  localparam int DW   = 6;
  localparam int DEF  = 12;
  localparam int PER  = (CLS + OPN) * DIV;
  localparam int LAT  = 10;  // frame start to acting edge

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1;
  logic          cmdValid = 1'b0;
  logic          cmdTrig = 1'b0;
  logic [2:0]    cmdDisable = 3'b000;
  logic          cmdDlyWr = 1'b0;
  logic [DW-1:0] cmdDelay = '0;
  logic          supplyOk = 1'b1;
  logic          wdReset;
  logic          errN;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  int fallCyc = 0;
  int riseCyc = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_window_wdog #(
    .PRESC_DIV(DIV), .CLOSED_TICKS(CLS), .OPEN_TICKS(OPN),
    .DLY_W(DW), .DEFAULT_DLY(DEF)
  ) i_spi_window_wdog (
    .clk(clk), .rstN(rstN), .csN(csN), .cmdValid(cmdValid), .cmdTrig(cmdTrig),
    .cmdDisable(cmdDisable), .cmdDlyWr(cmdDlyWr), .cmdDelay(cmdDelay),
    .supplyOk(supplyOk), .wdReset(wdReset), .errN(errN)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int expRise(input bit trig, input int d);
    if (!trig) return PER;
    if (d + LAT <= CLS * DIV) return d + LAT;
    return d + LAT + PER;
  endfunction

  task automatic waitFor(input logic val);
    while (wdReset !== val) @(negedge clk);
  endtask

  task automatic waitOff(input int d);
    while (cyc - fallCyc < d) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the acting edge
  task automatic frame(input bit useCmd, input bit trig, input logic [2:0] dis,
                       input bit dlyWr, input logic [DW-1:0] dly);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    if (useCmd) begin
      cmdValid = 1'b1; cmdTrig = trig; cmdDisable = dis;
      cmdDlyWr = dlyWr; cmdDelay = dly;
    end
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic faultCycle(input int expOff, input int expHold, input string tag);
    waitFor(1'b1);
    chk(cyc - fallCyc == expOff, {tag, " rise time"}, cyc - fallCyc, expOff);
    riseCyc = cyc;
    chk(errN == 1'b0, "R10 errN during hold", int'(errN), 0);
    waitFor(1'b0);
    chk(cyc - riseCyc == expHold, {tag, " hold length"}, cyc - riseCyc, expHold);
    fallCyc = cyc;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int highs;
    int effCyc;
    bit t;
    int d;
    logic [2:0] dis;
    repeat (5) @(negedge clk);
    chk(wdReset == 1'b0, "R6 wdReset in reset", int'(wdReset), 0);
    chk(errN == 1'b0, "R10 errN in reset", int'(errN), 0);
    rstN = 1'b1;
    fallCyc = cyc;
    repeat (10) @(negedge clk);
    chk(errN == 1'b1, "R10 errN idle", int'(errN), 1);
    chk(wdReset == 1'b0, "R5 no early reset", int'(wdReset), 0);

    // R5 timeout from reset, R8 default hold
    faultCycle(PER, DEF * DIV, "R5 R8 from reset");
    faultCycle(PER, DEF * DIV, "R5 timeout");

    // R4 read frames in closed and open windows
    waitOff(2);
    frame(1, 0, 3'b000, 0, '0);
    chk(wdReset == 1'b0, "R4 read in closed", int'(wdReset), 0);
    waitOff(30);
    frame(1, 0, 3'b000, 0, '0);
    faultCycle(PER, DEF * DIV, "R4 read in open");

    // R3 early service
    waitOff(5);
    frame(1, 1, 3'b000, 0, '0);
    chk(wdReset == 1'b1, "R3 early fault", int'(wdReset), 1);
    faultCycle(5 + LAT, DEF * DIV, "R3 R6");

    // R2 service in open window
    waitOff(30);
    frame(1, 1, 3'b000, 0, '0);
    faultCycle(30 + LAT + PER, DEF * DIV, "R2 service");

    // R1 strobe while chip select high, then empty frame
    waitOff(2);
    cmdValid = 1'b1; cmdTrig = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; cmdTrig = 1'b0;
    waitOff(6);
    frame(0, 1, 3'b000, 0, '0);
    chk(wdReset == 1'b0, "R1 dropped strobe", int'(wdReset), 0);
    faultCycle(PER, DEF * DIV, "R1 timing");

    // R9 written hold is kept
    waitOff(30);
    frame(1, 1, 3'b000, 1, DW'(5));
    faultCycle(30 + LAT + PER, 5 * DIV, "R9 written hold");
    faultCycle(PER, 5 * DIV, "R9 hold kept");

    // R8 supply drop restores default, R10 errN
    waitOff(10);
    supplyOk = 1'b0;
    repeat (3) @(negedge clk);
    chk(errN == 1'b0, "R10 errN supply low", int'(errN), 0);
    repeat (3) @(negedge clk);
    supplyOk = 1'b1;
    repeat (4) @(negedge clk);
    chk(errN == 1'b1, "R10 errN supply back", int'(errN), 1);
    faultCycle(PER, DEF * DIV, "R8 restored default");

    // R7 disable beats service, triggers ignored, re-enable
    waitOff(5);
    frame(1, 1, 3'b010, 0, '0);
    chk(wdReset == 1'b0, "R7 disable over service", int'(wdReset), 0);
    highs = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wdReset) highs++;
    end
    chk(highs == 0, "R7 stays off", highs, 0);
    frame(1, 1, 3'b010, 0, '0);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wdReset) highs++;
    end
    chk(highs == 0, "R7 trigger ignored while off", highs, 0);
    frame(1, 0, 3'b101, 0, '0);
    effCyc = cyc;
    fallCyc = effCyc;
    faultCycle(PER, DEF * DIV, "R7 re-enabled");

    // random frames, R2 R3 R4 with random non-off codes
    void'($urandom(32'h5eed));
    for (int k = 0; k < 24; k++) begin
      t = 1'($urandom % 2);
      d = ($urandom % 2) ? int'($urandom_range(0, 18)) : int'($urandom_range(26, 50));
      dis = 3'($urandom % 8);
      if (dis == 3'b010) dis = 3'b011;
      waitOff(d);
      frame(1, t, dis, 0, '0);
      faultCycle(expRise(t, d), DEF * DIV, "R2 R3 R4 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule